// File: doc/BRIEF.md
# Layer-Sequencing Training Controller

This controller drives one training iteration of a layered network. Software first writes the number of layers into a count register. A `go` pulse then starts the run. The controller reads a table with one row per layer and starts the execution engines for each layer over a start/done handshake. The engines are a forward engine, a backward engine, a weight-update engine and a bias-update engine. Only one engine runs at a time. The controller moves to the next layer only after every step of the current layer has finished.

The forward pass visits the rows from index 0 up to the last layer and starts only the forward engine. The backward pass then walks the same rows from the last index back to 0 and starts the backward engine for each layer. Layer kinds that carry weights also get the weight-update engine and then the bias-update engine, in that order. The fetched row is shown on a parameter bus, and it holds steady while an engine is working on it. The engines take their channel counts, geometry, layer links and memory offsets from that bus. A one-cycle pulse marks the end of the iteration.

The state machine has these states:
- ST_IDLE waits for `go`.
- ST_FETCH issues the table read.
- ST_LOAD captures the row and picks the first step.
- ST_FIRE emits the start pulse.
- ST_WAIT waits for the matching done.
- ST_NEXT moves the index or turns the pass around.
- ST_DONE emits the end pulse.

The transitions are:
- IDLE→FETCH on `go` with a non-zero count.
- FETCH→LOAD and LOAD→FIRE unconditionally.
- FIRE→WAIT unconditionally.
- WAIT→FIRE on done when a further update step is due.
- WAIT→NEXT on done otherwise.
- NEXT→FETCH to read another row, which includes the forward-to-backward turn that rereads the last row.
- NEXT→DONE after index 0 in the backward pass.
- DONE→IDLE unconditionally.

Top module: `layer_seq_ctrl`

## Requirements
- R1: In the forward pass the rows are visited in ascending index order 0..N-1, and for each row only the forward engine (`eng_start[0]`) is started.
- R2: After row N-1 finishes its forward step, the backward pass visits rows N-1 down to 0 and starts the backward engine (`eng_start[1]`) first for each row.
- R3: The row's kind field is bits [2:0], encoded convolution=0, batch-norm=1, scale=2, ReLU=3, pooling=4, element-wise=5, fully-connected=6, softmax=7. For kinds 0, 2 and 6 the backward step is followed by the weight-update engine (`eng_start[2]`) and then the bias-update engine (`eng_start[3]`). All other kinds get no update steps.
- R4: Each start is a single-cycle pulse. `prm_row` carries the fetched row, and `prm_kind` carries its bits [2:0]. Both stay unchanged from the start pulse until the matching done.
- R5: At most one engine is outstanding. A new start is issued only after the done of the previous start.
- R6: `iter_done` pulses for one cycle after the last backward step of row 0 completes, and the controller then returns to idle (`busy`=0).
- R7: A write through `cfg_we`/`cfg_layers` updates the layer count only while idle and only if the value is at most DEPTH. Any other write is ignored.
- R8: A `go` pulse while busy is ignored.
- R9: `go` with a layer count of 0 starts nothing.
- R10: A row is read by a one-cycle `tbl_rd_en` pulse with `tbl_addr` equal to the layer index. The data is taken one cycle later.
- R11: After reset, `busy`, `iter_done`, `tbl_rd_en` and `eng_start` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Layer-count write strobe |
| cfg_layers | input | CNT_W | Layer count to write |
| go | input | 1 | Start one training iteration |
| busy | output | 1 | Iteration in progress |
| iter_done | output | 1 | One-cycle end-of-iteration pulse |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_addr | output | IDX_W | Table row index |
| tbl_rd_data | input | ROW_W | Table row, valid one cycle after the strobe |
| eng_start | output | 4 | One-hot engine start: 0 fwd, 1 bwd, 2 weight, 3 bias |
| eng_done | input | 4 | Engine completion, same bit order |
| prm_row | output | ROW_W | Current layer row for the engines |
| prm_kind | output | 3 | Current layer kind |

## Verification
The bench fills the table with every layer kind in ascending and descending arrangements. It checks the full engine order against a list built from the requirements. A controller that skipped or mis-decoded the update steps would start engine 2 or 3 for a kind without weights, or miss them for scale and fully-connected layers. The bench also exercises the edges of the walk: a single layer, the full DEPTH table, and the turnaround that must reread the last row rather than skip it or step past it. An off-by-one here shows up as a wrong row on the parameter bus or a missing pulse. Other directed runs issue `go` and count writes mid-run, which would corrupt the layer count or restart the walk. Further runs use a zero count and an oversized count, as well as engine latencies of one to several cycles, so that a start fired before done or a parameter bus that changes while an engine works is caught.

// File: rtl/layer_seq_pkg.sv
package layer_seq_pkg;

    localparam int unsigned KIND_W      = 3;
    localparam int unsigned NUM_ENGINES = 4;

    typedef enum logic [KIND_W-1:0] {
        LK_CONV    = 3'd0,
        LK_BNORM   = 3'd1,
        LK_SCALE   = 3'd2,
        LK_RELU    = 3'd3,
        LK_POOL    = 3'd4,
        LK_ELTWISE = 3'd5,
        LK_FC      = 3'd6,
        LK_SOFTMAX = 3'd7
    } layer_kind_e;

    typedef enum logic [1:0] {
        EN_FWD  = 2'd0,
        EN_BWD  = 2'd1,
        EN_WUPD = 2'd2,
        EN_BUPD = 2'd3
    } engine_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_LOAD  = 3'd2,
        ST_FIRE  = 3'd3,
        ST_WAIT  = 3'd4,
        ST_NEXT  = 3'd5,
        ST_DONE  = 3'd6
    } seq_state_e;

endpackage

// File: rtl/lsq_kind_decode.sv
module lsq_kind_decode
    import layer_seq_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    output logic              has_upd
);

    always_comb begin
        unique case (layer_kind_e'(kind))
            LK_CONV, LK_SCALE, LK_FC: has_upd = 1'b1;
            default:                  has_upd = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsq_index_walker.sv
module lsq_index_walker #(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [IDX_W-1:0] idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (inc) begin
            idx <= idx + 1'b1;
        end else if (dec) begin
            idx <= idx - 1'b1;
        end
    end

    AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (idx != '0)) else $error("index decremented below zero"); // R2

    AST_ONE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec)) else $error("index moved both ways"); // R1

endmodule

// File: rtl/layer_seq_ctrl.sv
module layer_seq_ctrl
    import layer_seq_pkg::*;
#(
    parameter  int unsigned DEPTH = 16,
    parameter  int unsigned ROW_W = 64,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = IDX_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CNT_W-1:0]       cfg_layers,
    input  logic                   go,
    output logic                   busy,
    output logic                   iter_done,
    output logic                   tbl_rd_en,
    output logic [IDX_W-1:0]       tbl_addr,
    input  logic [ROW_W-1:0]       tbl_rd_data,
    output logic [NUM_ENGINES-1:0] eng_start,
    input  logic [NUM_ENGINES-1:0] eng_done,
    output logic [ROW_W-1:0]       prm_row,
    output logic [KIND_W-1:0]      prm_kind
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

    seq_state_e        state_q, state_n;
    engine_e           step_q, step_n;
    logic              bwd_q, bwd_n;
    logic [ROW_W-1:0]  row_q;
    logic              row_load;
    logic [CNT_W-1:0]  count_q;
    logic [IDX_W-1:0]  idx;
    logic              w_clr, w_inc, w_dec;
    logic              has_upd;
    logic              last_fwd;

    lsq_index_walker #(.IDX_W(IDX_W)) walker_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (w_clr),
        .inc   (w_inc),
        .dec   (w_dec),
        .idx   (idx)
    );

    lsq_kind_decode decode_i (
        .kind    (row_q[KIND_W-1:0]),
        .has_upd (has_upd)
    );

    assign last_fwd = (({1'b0, idx} + CNT_W'(1)) == count_q);

    // Next-state logic
    always_comb begin
        state_n  = state_q;
        step_n   = step_q;
        bwd_n    = bwd_q;
        row_load = 1'b0;
        w_clr    = 1'b0;
        w_inc    = 1'b0;
        w_dec    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go && (count_q != '0)) begin
                    state_n = ST_FETCH;
                    bwd_n   = 1'b0;
                    w_clr   = 1'b1;
                end
            end
            ST_FETCH: state_n = ST_LOAD;
            ST_LOAD: begin
                row_load = 1'b1;
                step_n   = bwd_q ? EN_BWD : EN_FWD;
                state_n  = ST_FIRE;
            end
            ST_FIRE: state_n = ST_WAIT;
            ST_WAIT: begin
                if (eng_done[step_q]) begin
                    if (step_q == EN_BWD && has_upd) begin
                        step_n  = EN_WUPD;
                        state_n = ST_FIRE;
                    end else if (step_q == EN_WUPD) begin
                        step_n  = EN_BUPD;
                        state_n = ST_FIRE;
                    end else begin
                        state_n = ST_NEXT;
                    end
                end
            end
            ST_NEXT: begin
                state_n = ST_FETCH;
                if (!bwd_q) begin
                    if (last_fwd) bwd_n = 1'b1;
                    else          w_inc = 1'b1;
                end else if (idx == '0) begin
                    state_n = ST_DONE;
                end else begin
                    w_dec = 1'b1;
                end
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= EN_FWD;
            bwd_q   <= 1'b0;
            row_q   <= '0;
            count_q <= '0;
        end else begin
            state_q <= state_n;
            step_q  <= step_n;
            bwd_q   <= bwd_n;
            if (row_load) row_q <= tbl_rd_data;
            if (cfg_we && (state_q == ST_IDLE) && (cfg_layers <= MAX_CNT))
                count_q <= cfg_layers;
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        tbl_rd_en = (state_q == ST_FETCH);
        tbl_addr  = idx;
        iter_done = (state_q == ST_DONE);
        eng_start = '0;
        if (state_q == ST_FIRE) eng_start[step_q] = 1'b1;
        prm_row   = row_q;
        prm_kind  = row_q[KIND_W-1:0];
    end

    AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_start)) else $error("several engines started"); // R5

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start != '0) |=> (eng_start == '0)) else $error("start wider than one cycle"); // R4

    AST_PARAM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> $stable(prm_row)) else $error("parameters moved during engine run"); // R4

    AST_UPD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start[2] || eng_start[3]) |->
            (prm_kind == 3'd0 || prm_kind == 3'd2 || prm_kind == 3'd6)) else $error("update on weightless kind"); // R3

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, tbl_addr} < count_q)) else $error("index beyond layer count"); // R1

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        iter_done |-> (tbl_addr == '0)) else $error("iteration ended away from row 0"); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        iter_done |=> !busy) else $error("not idle after iteration end"); // R6

    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(count_q)) else $error("layer count changed while busy"); // R7

endmodule

// File: tb/layer_seq_ctrl_tb_top.sv
module layer_seq_ctrl_tb_top;

    localparam int unsigned DEPTH = 16;
    localparam int unsigned ROW_W = 64;
    localparam int unsigned IDX_W = 4;
    localparam int unsigned CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [CNT_W-1:0] cfg_layers = '0;
    logic             go = 1'b0;
    logic             busy, iter_done, tbl_rd_en;
    logic [IDX_W-1:0] tbl_addr;
    logic [ROW_W-1:0] tbl_rd_data = '0;
    logic [3:0]       eng_start;
    logic [3:0]       eng_done = '0;
    logic [ROW_W-1:0] prm_row;
    logic [2:0]       prm_kind;

    always #5 clk = ~clk;

    layer_seq_ctrl #(.DEPTH(DEPTH), .ROW_W(ROW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_layers(cfg_layers), .go(go),
        .busy(busy), .iter_done(iter_done), .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr),
        .tbl_rd_data(tbl_rd_data), .eng_start(eng_start), .eng_done(eng_done),
        .prm_row(prm_row), .prm_kind(prm_kind)
    );

    int checks = 0;
    int errors = 0;

    logic [ROW_W-1:0] mem [DEPTH];
    always @(posedge clk) if (tbl_rd_en) tbl_rd_data <= mem[tbl_addr];

    // Engine model and event log
    int              ev_n = 0;
    int              ev_eng [256];
    logic [ROW_W-1:0] ev_row [256];
    int              lat = 1;
    int              pend = 0;
    int              cnt = 0;
    int              pend_eng = 0;
    logic [ROW_W-1:0] pend_row = '0;
    int              overlap_err = 0;
    int              stable_err = 0;
    int              pulse_err = 0;
    int              it_cnt = 0;
    logic [3:0]      prev_start = '0;

    always @(negedge clk) begin
        eng_done <= '0;
        if (iter_done) it_cnt++;
        if ((prev_start != 4'd0) && (eng_start != 4'd0)) pulse_err++;
        prev_start = eng_start;
        if (pend != 0) begin
            if (prm_row !== pend_row) stable_err++;
            if (cnt > 1) cnt--;
            else begin
                eng_done[pend_eng] <= 1'b1;
                pend = 0;
            end
        end
        if (eng_start != 4'd0) begin
            if (pend != 0) overlap_err++;
            for (int b = 0; b < 4; b++) if (eng_start[b]) pend_eng = b;
            if (ev_n < 256) begin
                ev_eng[ev_n] = pend_eng;
                ev_row[ev_n] = prm_row;
                ev_n++;
            end
            pend_row = prm_row;
            pend = 1;
            cnt = lat;
        end
    end

    task automatic check_eq(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit kind_upd(logic [2:0] k);
        return (k == 3'd0) || (k == 3'd2) || (k == 3'd6);
    endfunction

    task automatic fill_table(int mode);
        for (int i = 0; i < DEPTH; i++) begin
            logic [2:0] k;
            if (mode == 0)      k = 3'(i % 8);
            else if (mode == 1) k = 3'(7 - (i % 8));
            else                k = 3'd0;
            mem[i] = {32'(32'hC3A50000 + i * 32'h01010101 + mode), 29'(i + 7), k};
        end
    endtask

    task automatic write_count(int n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_layers = CNT_W'(n);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_iter(string tag);
        int base;
        int waited;
        base = it_cnt;
        ev_n = 0; overlap_err = 0; stable_err = 0; pulse_err = 0;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        waited = 0;
        while (it_cnt == base && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        @(negedge clk);
        check_eq({tag, " R6 one iter_done"}, it_cnt - base, 1);
        check_eq({tag, " R6 idle after"}, busy, 0);
        check_eq({tag, " R5 no overlapping engines"}, overlap_err, 0);
        check_eq({tag, " R4 params stable"}, stable_err, 0);
        check_eq({tag, " R4 single-cycle start"}, pulse_err, 0);
    endtask

    task automatic verify_seq(string tag, int n);
        int k;
        int errs;
        k = 0; errs = 0;
        for (int i = 0; i < n; i++) begin
            if (k < ev_n && (ev_eng[k] != 0 || ev_row[k] !== mem[i])) errs++;
            k++;
        end
        for (int i = n - 1; i >= 0; i--) begin
            if (k < ev_n && (ev_eng[k] != 1 || ev_row[k] !== mem[i])) errs++;
            k++;
            if (kind_upd(mem[i][2:0])) begin
                if (k < ev_n && (ev_eng[k] != 2 || ev_row[k] !== mem[i])) errs++;
                k++;
                if (k < ev_n && (ev_eng[k] != 3 || ev_row[k] !== mem[i])) errs++;
                k++;
            end
        end
        check_eq({tag, " R1 R2 R3 event count"}, ev_n, k);
        check_eq({tag, " R1 R2 R3 R10 order and rows"}, errs, 0);
    endtask

    task automatic t_reset;
        check_eq("R11 busy", busy, 0);
        check_eq("R11 iter_done", iter_done, 0);
        check_eq("R11 tbl_rd_en", tbl_rd_en, 0);
        check_eq("R11 eng_start", eng_start, 0);
    endtask

    task automatic t_all_kinds;
        fill_table(0); lat = 1;
        write_count(8);
        run_iter("all kinds");
        verify_seq("all kinds", 8);
    endtask

    task automatic t_single_conv;
        fill_table(2); lat = 2;
        write_count(1);
        run_iter("single");
        verify_seq("single", 1);
        check_eq("R3 single conv four steps", ev_n, 4);
    endtask

    task automatic t_full_depth;
        fill_table(1); lat = 4;
        write_count(DEPTH);
        run_iter("full");
        verify_seq("full", DEPTH);
    endtask

    task automatic t_busy_ignore;
        int base;
        int waited;
        fill_table(0); lat = 3;
        write_count(6);
        base = it_cnt;
        ev_n = 0; overlap_err = 0; stable_err = 0; pulse_err = 0;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        repeat (20) @(negedge clk);
        go = 1'b1; cfg_we = 1'b1; cfg_layers = CNT_W'(2);
        @(negedge clk); go = 1'b0; cfg_we = 1'b0;
        waited = 0;
        while (it_cnt == base && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        repeat (30) @(negedge clk);
        check_eq("R8 go while busy no restart", it_cnt - base, 1);
        check_eq("R8 idle after", busy, 0);
        verify_seq("busy-go", 6);
        run_iter("after-busy-write");
        verify_seq("R7 count kept after busy write", 6);
    endtask

    task automatic t_zero_count;
        write_count(0);
        ev_n = 0;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        repeat (20) @(negedge clk);
        check_eq("R9 zero count stays idle", busy, 0);
        check_eq("R9 zero count no starts", ev_n, 0);
        check_eq("R9 zero count no read", tbl_rd_en, 0);
    endtask

    task automatic t_oversize;
        fill_table(0); lat = 1;
        write_count(3);
        write_count(DEPTH + 4);
        run_iter("oversize");
        verify_seq("R7 oversize write ignored", 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_all_kinds();
        t_single_conv();
        t_full_depth();
        t_busy_ignore();
        t_zero_count();
        t_oversize();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule